// File: doc/BRIEF.md
# Dual-Channel DAC Command Controller

This block holds the register state behind a two-channel 14-bit digital-to-analog converter. A serial front end, outside this block, strips the bus framing and hands over bytes. Each byte arrives with a one-cycle valid strobe, and a transaction-active flag brackets every write. Each write carries three bytes. The first byte holds an operation nibble in bits 7:4 and a target nibble in bits 3:0. The second and third bytes form a 16-bit word, high byte first.

Each channel has a staging register and an output register. The output register drives the converter code. A channel can be put to sleep without losing either register. Any operation that refreshes a channel's output register wakes that channel, and so does a rising edge on an external load input. After a wake-up, a per-channel busy flag stays high for a settling window. The window is longer when both channels were asleep, because the shared bias circuit must restart as well.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: After reset, both output codes and both staging registers are zero, neither channel is asleep, and neither busy flag is set.
- R2: Operation 0x0 loads the staging register of each targeted channel and leaves every output code unchanged.
- R3: Operation 0x1 copies each targeted channel's staging register into its output register and clears that channel's sleep flag.
- R4: Operation 0x3 loads both the staging register and the output register of each targeted channel from the data word, and clears that channel's sleep flag.
- R5: Operation 0x4 sets the sleep flag of each targeted channel and changes neither of its registers. The data word of this operation has no effect.
- R6: Target 0x0 selects channel A, target 0x1 selects channel B, and target 0xF selects both channels.
- R7: Operation 0xF, any operation code other than 0x0, 0x1, 0x3, 0x4 and 0xF, and any target code other than 0x0, 0x1 and 0xF change no state.
- R8: The channel code is taken from bits 15:2 of the data word, and bits 1:0 are ignored.
- R9: An operation takes effect only when its third byte arrives. The registers update one clock after that byte is sampled. A transaction that ends after fewer bytes changes nothing.
- R10: A rising edge on `load_req` copies both staging registers into their output registers and wakes both channels. The edge passes through a two-flop synchronizer, so registers update on the third clock edge after the input rises. An edge seen while `xact_active` is high is ignored.
- R11: When a channel is woken while at most one channel is asleep, its busy flag is high for exactly `SETTLE_ONE` clock cycles. The window starts at the clock edge that updates the register.
- R12: When a channel is woken while both channels are asleep, its busy flag is high for exactly `SETTLE_BOTH` clock cycles.
- R13: An output update on a channel whose busy flag is high restarts that channel's settling window from its full length. A sleep operation clears the busy flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | One-cycle strobe marking a valid byte |
| byte_data | input | 8 | Received byte |
| xact_active | input | 1 | High for the duration of a write transaction |
| load_req | input | 1 | Asynchronous load input, acts on its rising edge |
| dac_a_code | output | 14 | Output register of channel A |
| dac_b_code | output | 14 | Output register of channel B |
| pwr_down | output | 2 | Sleep flag per channel, bit 0 = A |
| settle_busy | output | 2 | Settling-window flag per channel, bit 0 = A |

## Verification
The assertions check on every cycle that the output codes move only in the cycle after a decoded operation or a load pulse. They also check that reserved operations, sleep entry and load pulses during a transaction leave the output codes stable. Every cycle they confirm that a channel is never asleep and busy at once, and that a busy window only begins on a channel that was asleep. The exact length of the short and long settling windows, the restart of a running window, the discard of truncated transactions, the left-justified data field and the synchronizer latency of the load input are shown only by the bench's directed scenarios.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

    localparam int CODE_W = 14;
    localparam int WORD_W = 16;
    localparam int N_CH   = 2;

    localparam logic [3:0] OP_WR_IN  = 4'h0;
    localparam logic [3:0] OP_UPD    = 4'h1;
    localparam logic [3:0] OP_WR_UPD = 4'h3;
    localparam logic [3:0] OP_SLEEP  = 4'h4;
    localparam logic [3:0] OP_NOP    = 4'hF;

    localparam logic [3:0] TGT_A    = 4'h0;
    localparam logic [3:0] TGT_B    = 4'h1;
    localparam logic [3:0] TGT_BOTH = 4'hF;

    typedef struct packed {
        logic [3:0]        op;
        logic [3:0]        tgt;
        logic [CODE_W-1:0] code;
    } dac_cmd_t;

    function automatic logic op_known(input logic [3:0] op);
        return (op == OP_WR_IN) || (op == OP_UPD) || (op == OP_WR_UPD) ||
               (op == OP_SLEEP) || (op == OP_NOP);
    endfunction

    function automatic logic [N_CH-1:0] tgt_mask(input logic [3:0] tgt);
        case (tgt)
            TGT_A:    return 2'b01;
            TGT_B:    return 2'b10;
            TGT_BOTH: return 2'b11;
            default:  return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
    import dac_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_vld,
    input  logic [7:0] byte_data,
    input  logic       xact_active,
    output logic       cmd_vld,
    output dac_cmd_t   cmd
);
    localparam int LO_KEEP = CODE_W - 8;

    logic [1:0] idx_q;
    logic [7:0] head_q;
    logic [7:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            head_q  <= '0;
            hi_q    <= '0;
            cmd_vld <= 1'b0;
            cmd     <= '0;
        end else begin
            cmd_vld <= 1'b0;
            if (!xact_active) begin
                idx_q <= '0;
            end else if (byte_vld) begin
                case (idx_q)
                    2'd0: begin head_q <= byte_data; idx_q <= 2'd1; end
                    2'd1: begin hi_q   <= byte_data; idx_q <= 2'd2; end
                    2'd2: begin
                        cmd.op   <= head_q[7:4];
                        cmd.tgt  <= head_q[3:0];
                        cmd.code <= {hi_q, byte_data[7 -: LO_KEEP]};
                        cmd_vld  <= 1'b1;
                        idx_q    <= 2'd3;
                    end
                    default: idx_q <= 2'd3;
                endcase
            end
        end
    end
endmodule

// File: rtl/dac_load_sync.sv
module dac_load_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] sh_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            last_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], async_in};
            last_q <= sh_q[STAGES-1];
        end
    end

    assign rise = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/dac_settle_tmr.sv
module dac_settle_tmr #(
    parameter int SETTLE_ONE  = 625,
    parameter int SETTLE_BOTH = 1500
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic start_long,
    input  logic cancel,
    output logic busy
);
    localparam int CNT_W = $clog2(SETTLE_BOTH + 1);

    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || cancel)
            left_q <= '0;
        else if (start)
            left_q <= start_long ? CNT_W'(SETTLE_BOTH) : CNT_W'(SETTLE_ONE);
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign busy = (left_q != '0);
endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
    import dac_cmd_pkg::*;
#(
    parameter int SETTLE_ONE  = 625,
    parameter int SETTLE_BOTH = 1500,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              xact_active,
    input  logic              load_req,
    output logic [CODE_W-1:0] dac_a_code,
    output logic [CODE_W-1:0] dac_b_code,
    output logic [N_CH-1:0]   pwr_down,
    output logic [N_CH-1:0]   settle_busy
);
    dac_cmd_t          cmd_q;
    logic              cmd_vld;
    logic              ld_pulse;
    logic              ld_take;
    logic [N_CH-1:0]   sel;
    logic [CODE_W-1:0] stage_q [N_CH];
    logic [CODE_W-1:0] out_q   [N_CH];

    dac_frame_rx u_rx (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
        .xact_active(xact_active), .cmd_vld(cmd_vld), .cmd(cmd_q)
    );

    dac_load_sync #(.STAGES(SYNC_STAGES)) u_ldsync (
        .clk(clk), .rst(rst), .async_in(load_req), .rise(ld_pulse)
    );

    assign sel     = (cmd_vld && op_known(cmd_q.op)) ? tgt_mask(cmd_q.tgt) : '0;
    assign ld_take = ld_pulse && !xact_active && !cmd_vld;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic wr_stage, wr_out, go_sleep, wake_start;

        assign wr_stage   = sel[ch] && (cmd_q.op == OP_WR_IN || cmd_q.op == OP_WR_UPD);
        assign wr_out     = ld_take ||
                            (sel[ch] && (cmd_q.op == OP_UPD || cmd_q.op == OP_WR_UPD));
        assign go_sleep   = sel[ch] && (cmd_q.op == OP_SLEEP);
        assign wake_start = wr_out && (pwr_down[ch] || settle_busy[ch]);

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[ch]  <= '0;
                out_q[ch]    <= '0;
                pwr_down[ch] <= 1'b0;
            end else begin
                if (wr_stage)
                    stage_q[ch] <= cmd_q.code;
                if (wr_out) begin
                    out_q[ch]    <= (sel[ch] && cmd_q.op == OP_WR_UPD) ? cmd_q.code
                                                                       : stage_q[ch];
                    pwr_down[ch] <= 1'b0;
                end else if (go_sleep) begin
                    pwr_down[ch] <= 1'b1;
                end
            end
        end

        dac_settle_tmr #(.SETTLE_ONE(SETTLE_ONE), .SETTLE_BOTH(SETTLE_BOTH)) u_tmr (
            .clk(clk), .rst(rst), .start(wake_start),
            .start_long(&pwr_down), .cancel(go_sleep), .busy(settle_busy[ch])
        );
    end

    assign dac_a_code = out_q[0];
    assign dac_b_code = out_q[1];
endmodule

// File: rtl/dac_cmd_chk.sv
module dac_cmd_chk
    import dac_cmd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmd_vld,
    input logic [3:0]        cmd_op,
    input logic [3:0]        cmd_tgt,
    input logic              ld_pulse,
    input logic              xact_active,
    input logic [CODE_W-1:0] dac_a_code,
    input logic [CODE_W-1:0] dac_b_code,
    input logic [N_CH-1:0]   pwr_down,
    input logic [N_CH-1:0]   settle_busy
);
    // R2
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        (!cmd_vld && !ld_pulse) |=> ($stable(dac_a_code) && $stable(dac_b_code)));

    // R7
    reserved_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && (!op_known(cmd_op) || tgt_mask(cmd_tgt) == 2'b00 || cmd_op == OP_NOP))
        |=> ($stable(dac_a_code) && $stable(dac_b_code) && $stable(pwr_down)));

    // R5
    sleep_keeps_a_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_down[0]) |-> $stable(dac_a_code));

    // R5
    sleep_keeps_b_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_down[1]) |-> $stable(dac_b_code));

    // R10
    ld_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_pulse && xact_active && !cmd_vld) |=> ($stable(dac_a_code) && $stable(dac_b_code)));

    // R13
    no_sleep_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_down & settle_busy) == 2'b00);

    // R11
    busy_from_sleep_a_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(settle_busy[0]) |-> $past(pwr_down[0]));

    // R12
    busy_from_sleep_b_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(settle_busy[1]) |-> $past(pwr_down[1]));
endmodule

bind dac_cmd_ctrl dac_cmd_chk i_chk (
    .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_op(cmd_q.op), .cmd_tgt(cmd_q.tgt),
    .ld_pulse(ld_pulse), .xact_active(xact_active), .dac_a_code(dac_a_code),
    .dac_b_code(dac_b_code), .pwr_down(pwr_down), .settle_busy(settle_busy)
);

// File: tb/test_dac_cmd_ctrl.sv
module test_dac_cmd_ctrl;
    localparam int ONE  = 625;
    localparam int BOTH = 1500;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        xact_active = 1'b0;
    logic        load_req = 1'b0;
    logic [13:0] dac_a_code, dac_b_code;
    logic [1:0]  pwr_down, settle_busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dac_cmd_ctrl i_dac_cmd_ctrl (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
        .xact_active(xact_active), .load_req(load_req), .dac_a_code(dac_a_code),
        .dac_b_code(dac_b_code), .pwr_down(pwr_down), .settle_busy(settle_busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic send(input logic [3:0] op, input logic [3:0] tgt,
                        input logic [15:0] word, input int nbytes);
        logic [7:0] b [3];
        b[0] = {op, tgt}; b[1] = word[15:8]; b[2] = word[7:0];
        @(negedge clk); xact_active = 1'b1;
        for (int k = 0; k < nbytes; k++) begin
            @(negedge clk); byte_vld = 1'b1; byte_data = b[k];
        end
        @(negedge clk); byte_vld = 1'b0; xact_active = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_load();
        @(negedge clk); load_req = 1'b1;
        idle(3);
    endtask

    task automatic t_reset();
        chk("R1 dac_a", dac_a_code, 0);
        chk("R1 dac_b", dac_b_code, 0);
        chk("R1 pwr_down", pwr_down, 0);
        chk("R1 busy", settle_busy, 0);
    endtask

    task automatic t_write_then_update();
        send(4'h0, 4'h0, {14'h2ABC, 2'b11}, 3);
        chk("R2 stage only", dac_a_code, 0);
        send(4'h1, 4'h0, 16'hFFFF, 3);
        chk("R3 update A", dac_a_code, 14'h2ABC);
        chk("R8 low bits ignored", dac_a_code, 14'h2ABC);
        chk("R3 no busy when awake", settle_busy, 0);
    endtask

    task automatic t_targets();
        send(4'h3, 4'h1, {14'h1555, 2'b00}, 3);
        chk("R4 write+update B", dac_b_code, 14'h1555);
        chk("R6 A untouched", dac_a_code, 14'h2ABC);
        send(4'h0, 4'hF, {14'h0F0F, 2'b01}, 3);
        send(4'h1, 4'hF, 16'h0000, 3);
        chk("R6 both A", dac_a_code, 14'h0F0F);
        chk("R6 both B", dac_b_code, 14'h0F0F);
    endtask

    task automatic t_sleep_short();
        send(4'h4, 4'h0, 16'h1234, 3);
        chk("R5 sleep flag", pwr_down, 2'b01);
        chk("R5 code kept", dac_a_code, 14'h0F0F);
        send(4'h1, 4'h0, 16'h0000, 3);
        chk("R3 wake clears flag", pwr_down, 0);
        chk("R5 stage kept", dac_a_code, 14'h0F0F);
        idle(ONE - 1);
        chk("R11 busy at end", settle_busy, 2'b01);
        idle(1);
        chk("R11 busy cleared", settle_busy, 0);
    endtask

    task automatic t_sleep_long();
        send(4'h4, 4'hF, 16'h0000, 3);
        chk("R5 both asleep", pwr_down, 2'b11);
        send(4'h3, 4'h0, {14'h3333, 2'b10}, 3);
        chk("R4 wake A", pwr_down, 2'b10);
        chk("R4 code A", dac_a_code, 14'h3333);
        idle(ONE);
        chk("R12 busy past short", settle_busy[0], 1);
        idle(BOTH - ONE - 1);
        chk("R12 busy at end", settle_busy[0], 1);
        idle(1);
        chk("R12 busy cleared", settle_busy[0], 0);
        send(4'h1, 4'h1, 16'h0000, 3);
        idle(ONE);
        chk("R11 B short window", settle_busy, 0);
    endtask

    task automatic t_reserved();
        send(4'h2, 4'h0, {14'h0001, 2'b00}, 3);
        send(4'h3, 4'h5, {14'h0002, 2'b00}, 3);
        send(4'hF, 4'hF, {14'h0003, 2'b00}, 3);
        send(4'h4, 4'h7, 16'h0000, 3);
        chk("R7 A unchanged", dac_a_code, 14'h3333);
        chk("R7 B unchanged", dac_b_code, 14'h0F0F);
        chk("R7 no sleep", pwr_down, 0);
        send(4'h1, 4'hF, 16'h0000, 3);
        chk("R7 stage A unchanged", dac_a_code, 14'h3333);
    endtask

    task automatic t_truncated();
        send(4'h3, 4'h0, {14'h1111, 2'b00}, 2);
        chk("R9 two bytes dropped", dac_a_code, 14'h3333);
        send(4'h3, 4'h0, {14'h1111, 2'b00}, 1);
        chk("R9 one byte dropped", dac_a_code, 14'h3333);
        send(4'h3, 4'h0, {14'h1111, 2'b00}, 3);
        chk("R9 full frame", dac_a_code, 14'h1111);
    endtask

    task automatic t_load();
        send(4'h0, 4'h0, {14'h0AAA, 2'b00}, 3);
        send(4'h0, 4'h1, {14'h0BBB, 2'b00}, 3);
        @(negedge clk); load_req = 1'b1;
        idle(2);
        chk("R10 not before 3rd edge", dac_a_code, 14'h1111);
        idle(1);
        chk("R10 load A", dac_a_code, 14'h0AAA);
        chk("R10 load B", dac_b_code, 14'h0BBB);
        @(negedge clk); load_req = 1'b0;
        send(4'h0, 4'hF, {14'h0CCC, 2'b00}, 3);
        @(negedge clk); xact_active = 1'b1;
        idle(1); load_req = 1'b1;
        idle(5); xact_active = 1'b0;
        idle(4);
        chk("R10 ignored in transaction", dac_a_code, 14'h0AAA);
        load_req = 1'b0;
        send(4'h4, 4'hF, 16'h0000, 3);
        idle(2);
        pulse_load();
        chk("R10 wakes both", pwr_down, 0);
        chk("R10 loaded after sleep", dac_b_code, 14'h0CCC);
        idle(BOTH - 1);
        chk("R12 load long window", settle_busy, 2'b11);
        idle(1);
        chk("R12 load window over", settle_busy, 0);
        load_req = 1'b0;
    endtask

    task automatic t_restart();
        send(4'h4, 4'h0, 16'h0000, 3);
        send(4'h1, 4'h0, 16'h0000, 3);
        idle(100);
        send(4'h1, 4'h0, 16'h0000, 3);
        idle(ONE - 1);
        chk("R13 restarted window", settle_busy[0], 1);
        idle(1);
        chk("R13 restarted ends", settle_busy[0], 0);
        send(4'h4, 4'h1, 16'h0000, 3);
        send(4'h1, 4'h1, 16'h0000, 3);
        idle(10);
        send(4'h4, 4'h1, 16'h0000, 3);
        chk("R13 sleep cancels busy", settle_busy[1], 0);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_write_then_update();
        t_targets();
        t_sleep_short();
        t_sleep_long();
        t_reserved();
        t_truncated();
        t_load();
        t_restart();
        done = 1'b1;
    end

    initial begin
        for (int k = 0; k < 150000 && !done; k++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule